// File: doc/BRIEF.md
# Packed Integer Lane ALU

This block is a one-cycle arithmetic unit that treats its two 64-bit source buses as vectors of small integers. Two format bits choose the packing. A narrow/wide bit selects a 32-bit or a 64-bit vector. A byte/word bit selects 8-bit or 16-bit lanes. Every lane is computed at the same time and independently of the others. A carry or a product never crosses a lane edge.

A 4-bit operation code selects one of eight lane operations:
- add and subtract, both wrapping modulo the lane width;
- signed multiply, keeping either the low half or the high half of the double-width product;
- signed saturating add;
- unsigned saturating add;
- negate and absolute value, both of which read only the first source.

The caller presents the operands with a valid strobe. One clock later the registered result appears together with a valid flag. A 2-bit rounding-mode field must be zero to select integer lane semantics.

Top module: `simd_lane_alu`

## Requirements
- R1: The format bits select the lane layout as follows, with lane 0 in bits [7:0] or [15:0]. `fmt_wide`=0 and `fmt_word`=0 give four 8-bit lanes in bits [31:0]. `fmt_wide`=0 and `fmt_word`=1 give two 16-bit lanes in bits [31:0]. `fmt_wide`=1 and `fmt_word`=1 give four 16-bit lanes in bits [63:0].
- R2: Opcode 0 computes a+b per lane and opcode 1 computes a-b per lane. Both wrap modulo 2^lane-width.
- R3: Opcode 2 returns the low lane-width bits of the signed product a*b. Opcode 3 returns the high lane-width bits of that product.
- R4: Opcode 4 adds signed lanes. On overflow the lane clamps to the largest positive value (0x7F or 0x7FFF) or to the most negative value (0x80 or 0x8000).
- R5: Opcode 5 adds unsigned lanes. On a carry out the lane clamps to all ones.
- R6: Opcode 6 returns the two's-complement negation of each lane of `src_a`. Opcode 7 returns the absolute value of each lane of `src_a`, and the most negative lane value maps to itself. `src_b` has no effect on either result.
- R7: `fmt_wide`=1 with `fmt_word`=0 is a reserved format. In it the unit still processes eight 8-bit lanes over all 64 bits and raises `fmt_reserved` alongside the result. In every other format `fmt_reserved` is 0.
- R8: In both 32-bit formats, bits [63:32] of the result are zero, whatever the upper source bits hold.
- R9: `res_valid` is high exactly in the cycle after a cycle with `in_valid` high, and that result belongs to that input. While `in_valid` is low, `result` and `fmt_reserved` hold their values.
- R10: A rounding-mode value other than 00 gives a zero result. Opcodes 8 to 15 also give a zero result.
- R11: While `rst_n` is low, `res_valid`, `result` and `fmt_reserved` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| opcode | input | 4 | Lane operation select |
| fmt_wide | input | 1 | 0: 32-bit vector, 1: 64-bit vector |
| fmt_word | input | 1 | 0: 8-bit lanes, 1: 16-bit lanes |
| round_mode | input | 2 | Must be 00 for integer lane operations |
| src_a | input | 64 | First operand; the only operand for negate and absolute value |
| src_b | input | 64 | Second operand |
| res_valid | output | 1 | Result registered from the previous cycle's input |
| result | output | 64 | Packed lane result |
| fmt_reserved | output | 1 | The result was produced in the reserved 8x8-bit format |

## Verification
The bench targets the values that sit exactly at the lane edges, and each one catches a specific fault:
- 0xFF+0x01 in one lane next to a nonzero neighbour lane. A design that lets a carry leak across lanes corrupts the neighbour lane.
- 0x80*0x80 and -1*-1. A design that multiplies unsigned, or picks the wrong product half, returns the wrong high half.
- 0x7F+0x01 and 0x80+0xFF under signed saturation. A design that tests overflow on the wrong bits wraps instead of clamping, or clamps to the wrong end.
- Absolute value and negation of 0x80 and 0x8000. A design that saturates here, or reads `src_b`, returns a different value.
- Garbage in the upper source bits of a 32-bit format. A design that forgets the zeroing leaks that data into the result.
- The reserved format, a nonzero rounding mode and unused opcodes. A wrong design drops lanes, misses the flag or returns stale data.
- Back-to-back inputs and idle gaps. A design with the wrong latency, or one that does not hold its output, fails the scoreboard order.

// File: rtl/simd_alu_pkg.sv
// Package: shared widths and operation codes of the packed lane ALU.
// Assumes operation codes are 4 bits wide and codes 8..15 are unused.
package simd_alu_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    localparam logic [3:0] OP_ADD   = 4'd0;
    localparam logic [3:0] OP_SUB   = 4'd1;
    localparam logic [3:0] OP_MULLO = 4'd2;
    localparam logic [3:0] OP_MULHI = 4'd3;
    localparam logic [3:0] OP_ADDSS = 4'd4;
    localparam logic [3:0] OP_ADDUS = 4'd5;
    localparam logic [3:0] OP_NEG   = 4'd6;
    localparam logic [3:0] OP_ABS   = 4'd7;

    // Decoded format controls handed from the decoder to the result mux
    typedef struct packed {
        logic use_word;
        logic keep_upper;
        logic reserved;
        logic int_ok;
    } fmt_ctl_t;
endpackage

// File: rtl/simd_lane.sv
// Module: one integer lane of parameterised width W.
// Computes every operation code on a single lane, combinationally.
// Assumes opcodes above OP_ABS are filtered out downstream.
module simd_lane
    import simd_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

    logic signed [2*W-1:0] prod;
    logic        [W:0]     ssum;
    logic        [W:0]     usum;
    logic        [W-1:0]   negv;

    // Intermediate sums, product and negation for this lane
    always_comb begin
        prod = $signed(a) * $signed(b);
        ssum = {a[W-1], a} + {b[W-1], b};
        usum = {1'b0, a} + {1'b0, b};
        negv = '0 - a;
    end

    // Select the lane result by operation code
    always_comb begin
        case (op)
            OP_ADD:   y = a + b;
            OP_SUB:   y = a - b;
            OP_MULLO: y = prod[W-1:0];
            OP_MULHI: y = prod[2*W-1:W];
            OP_ADDSS: begin
                if (ssum[W] != ssum[W-1]) y = ssum[W] ? S_MIN : S_MAX;
                else                      y = ssum[W-1:0];
            end
            OP_ADDUS: y = usum[W] ? {W{1'b1}} : usum[W-1:0];
            OP_NEG:   y = negv;
            OP_ABS:   y = a[W-1] ? negv : a;
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/simd_fmt_decode.sv
// Module: decodes format bits and rounding mode into lane controls.
// Assumes rounding mode 00 is the only integer mode.
module simd_fmt_decode
    import simd_alu_pkg::*;
(
    input  logic       fmt_wide,
    input  logic       fmt_word,
    input  logic [1:0] round_mode,
    output fmt_ctl_t   ctl
);
    // Map the mode bits to lane width, upper-half use and validity
    always_comb begin
        ctl.use_word   = fmt_word;
        ctl.keep_upper = fmt_wide;
        ctl.reserved   = fmt_wide & ~fmt_word;
        ctl.int_ok     = (round_mode == 2'b00);
    end
endmodule

// File: rtl/simd_result_mux.sv
// Module: picks byte-lane or word-lane results and applies zeroing.
// Assumes both lane arrays were computed over the full DATA_W bits.
module simd_result_mux
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] byte_res,
    input  logic [DATA_W-1:0] word_res,
    input  fmt_ctl_t          ctl,
    input  logic              op_known,
    output logic [DATA_W-1:0] y
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] picked;

    // Choose the lane layout
    always_comb picked = ctl.use_word ? word_res : byte_res;

    // Zero the upper half in narrow formats and all of it for bad mode or opcode
    always_comb begin
        if (!ctl.int_ok || !op_known) y = '0;
        else if (!ctl.keep_upper)     y = {{HALF_W{1'b0}}, picked[HALF_W-1:0]};
        else                          y = picked;
    end
endmodule

// File: rtl/simd_lane_alu.sv
// Module: top of the packed integer lane ALU.
// Builds byte and word lane arrays, selects by format and registers the result.
// Assumes DATA_W is a multiple of WORD_W; synchronous active-low reset.
module simd_lane_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        opcode,
    input  logic              fmt_wide,
    input  logic              fmt_word,
    input  logic [1:0]        round_mode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              res_valid,
    output logic [DATA_W-1:0] result,
    output logic              fmt_reserved
);
    localparam int N_BYTE = DATA_W / BYTE_W;
    localparam int N_WORD = DATA_W / WORD_W;

    logic [DATA_W-1:0] byte_res;
    logic [DATA_W-1:0] word_res;
    logic [DATA_W-1:0] next_res;
    logic              op_known;
    fmt_ctl_t          ctl;

    for (genvar i = 0; i < N_BYTE; i++) begin : g_byte
        simd_lane #(.W(BYTE_W)) u_lane (
            .op (opcode),
            .a  (src_a[i*BYTE_W +: BYTE_W]),
            .b  (src_b[i*BYTE_W +: BYTE_W]),
            .y  (byte_res[i*BYTE_W +: BYTE_W])
        );
    end

    for (genvar j = 0; j < N_WORD; j++) begin : g_word
        simd_lane #(.W(WORD_W)) u_lane (
            .op (opcode),
            .a  (src_a[j*WORD_W +: WORD_W]),
            .b  (src_b[j*WORD_W +: WORD_W]),
            .y  (word_res[j*WORD_W +: WORD_W])
        );
    end

    simd_fmt_decode u_dec (
        .fmt_wide   (fmt_wide),
        .fmt_word   (fmt_word),
        .round_mode (round_mode),
        .ctl        (ctl)
    );

    // Opcodes 0..7 are defined, 8..15 yield zero
    always_comb op_known = ~opcode[3];

    simd_result_mux #(.DATA_W(DATA_W)) u_mux (
        .byte_res (byte_res),
        .word_res (word_res),
        .ctl      (ctl),
        .op_known (op_known),
        .y        (next_res)
    );

    // Output register: capture on valid input, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            result       <= '0;
            fmt_reserved <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                result       <= next_res;
                fmt_reserved <= ctl.reserved;
            end
        end
    end
endmodule

// File: rtl/simd_lane_alu_chk.sv
// Module: property checker for simd_lane_alu, bound to every instance.
// Assumes the default 64-bit data width.
module simd_lane_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [3:0]  opcode,
    input logic        fmt_wide,
    input logic        fmt_word,
    input logic [1:0]  round_mode,
    input logic [63:0] src_a,
    input logic [63:0] src_b,
    input logic        res_valid,
    input logic [63:0] result,
    input logic        fmt_reserved
);
    // R9: valid follows input one cycle later
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);
    // R9: result holds while idle
    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(fmt_reserved)));
    // R8: narrow formats never drive upper bits
    a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !fmt_wide) |=> (result[63:32] == 32'h0));
    // R7: reserved flag tracks the reserved format pair
    a_r7_reserved_flag: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (fmt_reserved == ($past(fmt_wide) && !$past(fmt_word))));
    // R10: non-integer rounding mode gives zero
    a_r10_mode_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && round_mode != 2'b00) |=> (result == 64'h0));
    // R2: adding zero in a wide format returns the first operand
    a_r2_add_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 4'd0 && round_mode == 2'b00 && fmt_wide && src_b == 64'h0)
        |=> (result == $past(src_a)));
endmodule

bind simd_lane_alu simd_lane_alu_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .opcode       (opcode),
    .fmt_wide     (fmt_wide),
    .fmt_word     (fmt_word),
    .round_mode   (round_mode),
    .src_a        (src_a),
    .src_b        (src_b),
    .res_valid    (res_valid),
    .result       (result),
    .fmt_reserved (fmt_reserved)
);

// File: tb/simd_lane_alu_test.sv
// Bench: scoreboard for simd_lane_alu. Driver pushes expected items,
// monitor pops and compares them on each valid result.
module simd_lane_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  opcode = '0;
    logic        fmt_wide = 1'b0;
    logic        fmt_word = 1'b0;
    logic [1:0]  round_mode = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        res_valid;
    logic [63:0] result;
    logic        fmt_reserved;

    int n_cmp = 0;
    int n_bad = 0;
    logic [64:0] exp_q[$];
    string       tag_q[$];
    logic [63:0] last_res = '0;
    logic        last_rsv = 1'b0;
    bit          done = 1'b0;

    simd_lane_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .fmt_wide(fmt_wide), .fmt_word(fmt_word), .round_mode(round_mode),
        .src_a(src_a), .src_b(src_b), .res_valid(res_valid),
        .result(result), .fmt_reserved(fmt_reserved)
    );

    always #2 clk = ~clk;

    function automatic longint sext(longint v, int w);
        return (v >= (longint'(1) << (w - 1))) ? v - (longint'(1) << w) : v;
    endfunction

    // Reference model written from the requirements
    function automatic logic [64:0] model(logic [3:0] op, logic wd, logic wo,
                                          logic [1:0] rm, logic [63:0] a, logic [63:0] b);
        logic [63:0] r = '0;
        int lw = wo ? 16 : 8;
        int nl = (wd ? 64 : 32) / lw;
        longint mask = (longint'(1) << lw) - 1;
        longint smax = (longint'(1) << (lw - 1)) - 1;
        longint smin = -(longint'(1) << (lw - 1));
        for (int i = 0; i < nl; i++) begin
            longint x = longint'((a >> (i * lw)) & 64'(mask));
            longint z = longint'((b >> (i * lw)) & 64'(mask));
            longint sx = sext(x, lw);
            longint sz = sext(z, lw);
            longint v = 0;
            case (op)
                4'd0: v = x + z;
                4'd1: v = x - z;
                4'd2: v = sx * sz;
                4'd3: v = (sx * sz) >>> lw;
                4'd4: begin
                    v = sx + sz;
                    if (v > smax) v = smax;
                    if (v < smin) v = smin;
                end
                4'd5: begin
                    v = x + z;
                    if (v > mask) v = mask;
                end
                4'd6: v = -sx;
                4'd7: v = (sx < 0) ? -sx : sx;
                default: v = 0;
            endcase
            r = r | (64'(v & mask) << (i * lw));
        end
        if (rm != 2'b00) r = '0;
        return {wd & ~wo, r};
    endfunction

    // Driver: one valid input cycle, expected item queued
    task automatic drive(string tag, logic [3:0] op, logic wd, logic wo,
                         logic [1:0] rm, logic [63:0] a, logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1; opcode = op; fmt_wide = wd; fmt_word = wo;
        round_mode = rm; src_a = a; src_b = b;
        exp_q.push_back(model(op, wd, wo, rm, a, b));
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            src_a = {$urandom, $urandom};
            src_b = {$urandom, $urandom};
        end
    endtask

    // Monitor: compare results away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (res_valid) begin
                logic [64:0] e;
                string t;
                n_cmp++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R9 unexpected valid: actual %h expected none", result);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if ({fmt_reserved, result} !== e) begin
                        n_bad++;
                        $display("FAIL %s: actual rsv=%b res=%h expected rsv=%b res=%h",
                                 t, fmt_reserved, result, e[64], e[63:0]);
                    end
                end
                last_res = result;
                last_rsv = fmt_reserved;
            end else begin
                // R9 hold check while idle
                n_cmp++;
                if (result !== last_res || fmt_reserved !== last_rsv) begin
                    n_bad++;
                    $display("FAIL R9 hold: actual %h expected %h", result, last_res);
                end
            end
        end
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_cmp++;
        if (res_valid !== 1'b0 || result !== 64'h0 || fmt_reserved !== 1'b0) begin
            n_bad++;
            $display("FAIL R11 reset: actual v=%b r=%h f=%b expected 0 0 0",
                     res_valid, result, fmt_reserved);
        end
        @(negedge clk); rst_n = 1'b1;

        // R1 / R2: lane layouts with carries at lane edges
        drive("R2", 4'd0, 1'b0, 1'b0, 2'b00, 64'hDEAD_BEEF_01FF_7F10, 64'h1234_5678_0201_0110);
        drive("R2", 4'd1, 1'b0, 1'b0, 2'b00, 64'h0000_0000_0000_0100, 64'h0000_0000_0001_0001);
        drive("R1", 4'd0, 1'b0, 1'b1, 2'b00, 64'h0000_0000_FFFF_8000, 64'h0000_0000_0001_8000);
        drive("R1", 4'd1, 1'b1, 1'b1, 2'b00, 64'h0001_0000_FFFF_1234, 64'h0002_0001_0001_0234);
        // R3: signed products at the extremes
        drive("R3", 4'd2, 1'b0, 1'b0, 2'b00, 64'h0000_0000_80FF_0307, 64'h0000_0000_80FF_FD07);
        drive("R3", 4'd3, 1'b0, 1'b0, 2'b00, 64'h0000_0000_80FF_0307, 64'h0000_0000_80FF_FD07);
        drive("R3", 4'd3, 1'b1, 1'b1, 2'b00, 64'h8000_FFFF_7FFF_0100, 64'h8000_FFFF_7FFF_FF00);
        idle(3);
        // R4 / R5: saturation both ways
        drive("R4", 4'd4, 1'b0, 1'b0, 2'b00, 64'h0000_0000_7F80_4010, 64'h0000_0000_01FF_4020);
        drive("R4", 4'd4, 1'b1, 1'b1, 2'b00, 64'h7FFF_8000_0005_FFFF, 64'h0001_FFFF_FFF0_0001);
        drive("R5", 4'd5, 1'b0, 1'b0, 2'b00, 64'h0000_0000_FF80_7F01, 64'h0000_0000_0180_0102);
        drive("R5", 4'd5, 1'b1, 1'b1, 2'b00, 64'hFFFF_8000_0001_1234, 64'h0001_8000_0002_0001);
        // R6: single-operand ops, src_b must not matter
        drive("R6", 4'd6, 1'b0, 1'b0, 2'b00, 64'h0000_0000_8001_FF00, 64'hFFFF_FFFF_FFFF_FFFF);
        drive("R6", 4'd7, 1'b0, 1'b0, 2'b00, 64'h0000_0000_80FE_7F00, 64'h1234_5678_9ABC_DEF0);
        drive("R6", 4'd7, 1'b1, 1'b1, 2'b00, 64'h8000_FFFE_7FFF_0003, 64'h5555_AAAA_5555_AAAA);
        idle(2);
        // R7: reserved format, eight byte lanes
        drive("R7", 4'd0, 1'b1, 1'b0, 2'b00, 64'hFF01_0203_0405_0607, 64'h0101_0101_0101_0101);
        drive("R7", 4'd4, 1'b1, 1'b0, 2'b00, 64'h7F80_0000_0000_0000, 64'h01FF_0000_0000_0000);
        // R8: garbage upper halves in narrow formats
        drive("R8", 4'd0, 1'b0, 1'b1, 2'b00, 64'hFFFF_FFFF_0001_0002, 64'hAAAA_AAAA_0001_0002);
        drive("R8", 4'd2, 1'b0, 1'b0, 2'b00, 64'hFFFF_FFFF_0203_0405, 64'hFFFF_FFFF_0203_0405);
        // R10: non-integer mode and unused opcodes
        drive("R10", 4'd0, 1'b1, 1'b1, 2'b01, 64'h1111_2222_3333_4444, 64'h1111_1111_1111_1111);
        drive("R10", 4'd9, 1'b1, 1'b1, 2'b00, 64'h1111_2222_3333_4444, 64'h1111_1111_1111_1111);
        drive("R10", 4'd15, 1'b0, 1'b0, 2'b00, 64'h1111_2222_3333_4444, 64'h1111_1111_1111_1111);
        idle(4);
        // R9: back-to-back stream in mixed formats
        for (int i = 0; i < 40; i++)
            drive("R9", 4'(i % 8), 1'((i / 2) % 2), 1'(i % 3 != 0), 2'b00,
                  {$urandom, $urandom}, {$urandom, $urandom});
        idle(5);

        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R9 missing results: actual %0d left expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule